// File: doc/BRIEF.md
# Cache Block State and Lock Array

This block keeps the metadata for every block of a small set-associative data cache: an address tag, a two-bit coherency state and a lock flag. It stores no data, drives no external bus and does not sequence refills. A cache controller around it presents one request per cycle: a lookup for a read or a write, a fill that allocates a block, or one of the maintenance commands (lock, unlock, unlock everything, invalidate one block, invalidate everything). The result comes back on a registered response one cycle later.

There is no snoop input. Only local requests change the state, so keeping the cache coherent with external agents is left to software. Software can load a block and then lock it, which keeps it resident. The victim chooser for fills never picks a locked block. When every way of the set is locked, the fill reports that it cannot allocate and the set is left as it was.

Top module: `cmeta_array`

## Requirements
- R1: During reset `rsp_valid` is low. After reset every block is invalid and unlocked, so any lookup misses, including one whose tag equals the reset tag value of zero.
- R2: For each cycle with `req_valid` high, `rsp_valid` is high in the following cycle. Otherwise it is low. Opcodes on `req_op` are: 0 no-op, 1 read, 2 write, 3 fill, 4 lock, 5 unlock, 6 unlock all, 7 invalidate one, 8 invalidate all. Codes 9 to 15 act as no-ops. States on `rsp_state` are 00 invalid, 01 clean valid and 11 modified valid. The code 10 is never stored. A read that hits reports `rsp_hit`, the way, the block's state and its lock flag.
- R3: A write that hits makes the block modified valid. A write that misses raises `rsp_miss` and allocates nothing.
- R4: A lock command that hits sets the block's lock flag and leaves its state unchanged. A locked block is always valid.
- R5: An unlock command that hits clears only that block's lock flag.
- R6: Unlock-all clears every lock flag in the array within the single cycle of the command.
- R7: A fill whose tag is already resident changes nothing and reports a hit. Otherwise it takes the lowest-numbered invalid way. If the set has no invalid way, it takes the first unlocked way, scanning upward (with wraparound) from the set's round-robin pointer. The block gets the new tag, clean state and a cleared lock flag, and the set's pointer becomes victim+1 modulo the number of ways. If every way is locked, `rsp_no_alloc` is high and nothing changes.
- R8: A fill that evicts a modified-valid block raises `rsp_wb`. `rsp_wb` is low for every other response.
- R9: Lock, unlock or invalidate of a block that is not resident changes nothing and raises `rsp_miss`.
- R10: An invalidate that hits makes the block invalid and clears its lock flag.
- R11: Invalidate-all makes every block invalid and clears every lock flag within the single cycle of the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 4 | Request opcode (see R2) |
| req_set | input | SET_W | Set index of the request |
| req_tag | input | TAG_W | Tag of the request |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_hit | output | 1 | Tag found resident |
| rsp_miss | output | 1 | Addressed block was not resident |
| rsp_way | output | WAY_W | Way that hit or was allocated |
| rsp_state | output | 2 | State of that block after the request |
| rsp_locked | output | 1 | Lock flag of that block after the request |
| rsp_no_alloc | output | 1 | Fill refused because every way is locked |
| rsp_wb | output | 1 | Fill evicted a modified block |

## Verification
Some rules hold on every cycle, and the assertions check them there. No block ever holds the unused state code, and no locked block is invalid. A lookup never matches more than one way. A chosen victim is never locked, and a refused fill happens only when the whole set is locked. Unlock-all and invalidate-all take effect in one cycle, and a write hit comes back modified. The bench scenarios cover the rules that depend on ordering: the invalid-first and round-robin victim order, the write-back flag, the miss flag on lock and unlock of non-resident tags, and the point that such commands leave later lookups unchanged. A behavioural reference model checks every response of a long random sequence.

// File: rtl/cmeta_pkg.sv
// Package: shared encodings for the cache metadata array.
// Assumes: two-bit state codes and a four-bit opcode field.
package cmeta_pkg;

    typedef enum logic [1:0] {
        BLK_INV   = 2'b00,
        BLK_CLEAN = 2'b01,
        BLK_DIRTY = 2'b11
    } blk_state_e;

    typedef enum logic [3:0] {
        OP_NOP        = 4'd0,
        OP_READ       = 4'd1,
        OP_WRITE      = 4'd2,
        OP_FILL       = 4'd3,
        OP_LOCK       = 4'd4,
        OP_UNLOCK     = 4'd5,
        OP_UNLOCK_ALL = 4'd6,
        OP_INV        = 4'd7,
        OP_INV_ALL    = 4'd8
    } meta_op_e;

endpackage

// File: rtl/cmeta_lookup.sv
// Module: cmeta_lookup
// Compares a request tag against every way of one set and reports which
// way holds it. Only valid ways may match.
// Assumes: fills never duplicate a resident tag, so at most one way matches.
module cmeta_lookup #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 8,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [WAYS-1:0][TAG_W-1:0] set_tags,
    input  logic [WAYS-1:0]            set_vld,
    input  logic [TAG_W-1:0]           look_tag,
    output logic                       look_hit,
    output logic [WAY_W-1:0]           look_way
);

    logic [WAYS-1:0] match_vec;

    // One comparator per way.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match_vec[w] = set_vld[w] && (set_tags[w] == look_tag);
    end

    // Encode the matching way (lowest index wins if ever more than one).
    always_comb begin
        look_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match_vec[w]) look_way = WAY_W'(w);
        end
    end

    assign look_hit = |match_vec;

    // R2: a tag is resident in at most one way of a set
    a_r2_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_vec));

endmodule

// File: rtl/cmeta_victim.sv
// Module: cmeta_victim
// Chooses the way a fill replaces: the lowest invalid way first, then the
// first unlocked way scanning upward from the round-robin pointer.
// Assumes: WAYS is a power of two so the scan index wraps naturally;
// invalid ways are never locked.
module cmeta_victim #(
    parameter int WAYS = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WAYS-1:0]  set_vld,
    input  logic [WAYS-1:0]  set_lock,
    input  logic [WAY_W-1:0] rr_ptr,
    output logic [WAY_W-1:0] vic_way,
    output logic             vic_found
);

    logic             inv_found;
    logic [WAY_W-1:0] inv_way;
    logic             rr_found;
    logic [WAY_W-1:0] rr_way;

    // Lowest-numbered invalid way.
    always_comb begin
        inv_found = 1'b0;
        inv_way   = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!set_vld[w]) begin
                inv_found = 1'b1;
                inv_way   = WAY_W'(w);
            end
        end
    end

    // First unlocked way at or after the round-robin pointer, wrapping.
    always_comb begin
        logic [WAY_W-1:0] idx;
        rr_found = 1'b0;
        rr_way   = '0;
        for (int k = 0; k < WAYS; k++) begin
            idx = rr_ptr + WAY_W'(k);
            if (!rr_found && !set_lock[idx]) begin
                rr_found = 1'b1;
                rr_way   = idx;
            end
        end
    end

    // Invalid ways take precedence over round-robin replacement.
    assign vic_found = inv_found | rr_found;
    assign vic_way   = inv_found ? inv_way : rr_way;

    // R7: a chosen victim is never a locked block
    a_r7_victim_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        vic_found |-> !set_lock[vic_way]);

    // R7: refusing to allocate only happens with every way locked
    a_r7_refuse_all_locked: assert property (@(posedge clk) disable iff (!rst_n)
        !vic_found |-> (&set_lock));

endmodule

// File: rtl/cmeta_array.sv
// Module: cmeta_array (top)
// Holds tag, two-bit state and lock flag for each block of a set-associative
// data cache and serves one request per cycle with a registered response.
// No snoop port: only local requests change the state.
// Assumes: SETS and WAYS are powers of two, WAYS >= 2; the controller issues
// fills only for lines it will then load.
module cmeta_array
    import cmeta_pkg::*;
#(
    parameter int SETS  = 8,
    parameter int WAYS  = 4,
    parameter int TAG_W = 8,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [3:0]       req_op,
    input  logic [SET_W-1:0] req_set,
    input  logic [TAG_W-1:0] req_tag,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_miss,
    output logic [WAY_W-1:0] rsp_way,
    output logic [1:0]       rsp_state,
    output logic             rsp_locked,
    output logic             rsp_no_alloc,
    output logic             rsp_wb
);

    // Metadata storage.
    logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag_q;
    logic [SETS-1:0][WAYS-1:0][1:0]       st_q;
    logic [SETS-1:0][WAYS-1:0]            lk_q;
    logic [SETS-1:0][WAY_W-1:0]           rr_q;

    // Selected set row.
    logic [WAYS-1:0][TAG_W-1:0] cur_tags;
    logic [WAYS-1:0][1:0]       cur_st;
    logic [WAYS-1:0]            cur_lk;
    logic [WAYS-1:0]            cur_vld;
    logic [WAY_W-1:0]           cur_rr;

    // Row after the request.
    logic [WAYS-1:0][TAG_W-1:0] row_tag;
    logic [WAYS-1:0][1:0]       row_st;
    logic [WAYS-1:0]            row_lk;
    logic [WAY_W-1:0]           row_rr;

    logic             hit;
    logic [WAY_W-1:0] hit_way;
    logic             vic_found;
    logic [WAY_W-1:0] vic_way;

    logic             r_hit, r_miss, r_lock, r_noalloc, r_wb;
    logic [WAY_W-1:0] r_way;
    logic [1:0]       r_state;
    meta_op_e         op;

    assign op       = meta_op_e'(req_op);
    assign cur_tags = tag_q[req_set];
    assign cur_st   = st_q[req_set];
    assign cur_lk   = lk_q[req_set];
    assign cur_rr   = rr_q[req_set];

    // A way is valid when its state is not invalid.
    for (genvar w = 0; w < WAYS; w++) begin : g_vld
        assign cur_vld[w] = (cur_st[w] != BLK_INV);
    end

    cmeta_lookup #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lookup (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_tags (cur_tags),
        .set_vld  (cur_vld),
        .look_tag (req_tag),
        .look_hit (hit),
        .look_way (hit_way)
    );

    cmeta_victim #(.WAYS(WAYS)) u_victim (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_vld   (cur_vld),
        .set_lock  (cur_lk),
        .rr_ptr    (cur_rr),
        .vic_way   (vic_way),
        .vic_found (vic_found)
    );

    // Compute the updated row and the response for a per-block request.
    always_comb begin
        row_tag   = cur_tags;
        row_st    = cur_st;
        row_lk    = cur_lk;
        row_rr    = cur_rr;
        r_hit     = 1'b0;
        r_miss    = 1'b0;
        r_way     = '0;
        r_state   = BLK_INV;
        r_lock    = 1'b0;
        r_noalloc = 1'b0;
        r_wb      = 1'b0;
        case (op)
            OP_READ, OP_WRITE, OP_LOCK, OP_UNLOCK, OP_INV: begin
                if (hit) begin
                    r_hit = 1'b1;
                    r_way = hit_way;
                    case (op)
                        OP_WRITE:  row_st[hit_way] = BLK_DIRTY;
                        OP_LOCK:   row_lk[hit_way] = 1'b1;
                        OP_UNLOCK: row_lk[hit_way] = 1'b0;
                        OP_INV: begin
                            row_st[hit_way] = BLK_INV;
                            row_lk[hit_way] = 1'b0;
                        end
                        default: ;
                    endcase
                    r_state = row_st[hit_way];
                    r_lock  = row_lk[hit_way];
                end else begin
                    r_miss = 1'b1;
                end
            end
            OP_FILL: begin
                if (hit) begin
                    r_hit   = 1'b1;
                    r_way   = hit_way;
                    r_state = cur_st[hit_way];
                    r_lock  = cur_lk[hit_way];
                end else if (vic_found) begin
                    row_tag[vic_way] = req_tag;
                    row_st[vic_way]  = BLK_CLEAN;
                    row_lk[vic_way]  = 1'b0;
                    row_rr           = vic_way + WAY_W'(1);
                    r_way            = vic_way;
                    r_state          = BLK_CLEAN;
                    r_wb             = (cur_st[vic_way] == BLK_DIRTY);
                end else begin
                    r_noalloc = 1'b1;
                end
            end
            default: ;
        endcase
    end

    // Update storage: whole-array commands or write back the selected row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q <= '0;
            st_q  <= '0;
            lk_q  <= '0;
            rr_q  <= '0;
        end else if (req_valid) begin
            if (op == OP_INV_ALL) begin
                st_q <= '0;
                lk_q <= '0;
            end else if (op == OP_UNLOCK_ALL) begin
                lk_q <= '0;
            end else begin
                tag_q[req_set] <= row_tag;
                st_q[req_set]  <= row_st;
                lk_q[req_set]  <= row_lk;
                rr_q[req_set]  <= row_rr;
            end
        end
    end

    // Register the response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_hit      <= 1'b0;
            rsp_miss     <= 1'b0;
            rsp_way      <= '0;
            rsp_state    <= BLK_INV;
            rsp_locked   <= 1'b0;
            rsp_no_alloc <= 1'b0;
            rsp_wb       <= 1'b0;
        end else begin
            rsp_valid    <= req_valid;
            rsp_hit      <= req_valid & r_hit;
            rsp_miss     <= req_valid & r_miss;
            rsp_way      <= req_valid ? r_way : '0;
            rsp_state    <= req_valid ? r_state : BLK_INV;
            rsp_locked   <= req_valid & r_lock;
            rsp_no_alloc <= req_valid & r_noalloc;
            rsp_wb       <= req_valid & r_wb;
        end
    end

    // Per-block invariants.
    for (genvar s = 0; s < SETS; s++) begin : g_chk_set
        for (genvar w = 0; w < WAYS; w++) begin : g_chk_way
            // R2: the unused state code is never stored
            a_r2_legal_state: assert property (@(posedge clk) disable iff (!rst_n)
                st_q[s][w] != 2'b10);
            // R4: a locked block is always resident
            a_r4_lock_resident: assert property (@(posedge clk) disable iff (!rst_n)
                lk_q[s][w] |-> (st_q[s][w] != BLK_INV));
        end
    end

    // R6: unlock-all leaves no lock flag set one cycle later
    a_r6_unlock_all: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == OP_UNLOCK_ALL) |=> (lk_q == '0));

    // R11: invalidate-all leaves no valid and no locked block
    a_r11_inv_all: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == OP_INV_ALL) |=> (st_q == '0 && lk_q == '0));

    // R3: a write hit answers with the modified state
    a_r3_write_dirty: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == OP_WRITE && hit) |=> (rsp_hit && rsp_state == BLK_DIRTY));

    // R9: a lock aimed at a non-resident tag reports a miss and locks nothing
    a_r9_lock_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == OP_LOCK && !hit) |=> (rsp_miss && !rsp_locked));

endmodule

// File: tb/cmeta_array_tb.sv
module cmeta_array_tb;
    import cmeta_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int SETS  = 8;
    localparam int WAYS  = 4;
    localparam int TAG_W = 8;
    localparam int SET_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [3:0]       req_op = '0;
    logic [SET_W-1:0] req_set = '0;
    logic [TAG_W-1:0] req_tag = '0;
    logic             rsp_valid, rsp_hit, rsp_miss, rsp_locked, rsp_no_alloc, rsp_wb;
    logic [WAY_W-1:0] rsp_way;
    logic [1:0]       rsp_state;

    int n_chk  = 0;
    int n_fail = 0;

    // Reference model state.
    int m_tag [SETS][WAYS];
    int m_st  [SETS][WAYS];
    bit m_lk  [SETS][WAYS];
    int m_rr  [SETS];

    always #(CLK_PERIOD / 2) clk = ~clk;

    cmeta_array #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_dut (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_op (req_op),
        .req_set (req_set), .req_tag (req_tag), .rsp_valid (rsp_valid),
        .rsp_hit (rsp_hit), .rsp_miss (rsp_miss), .rsp_way (rsp_way),
        .rsp_state (rsp_state), .rsp_locked (rsp_locked),
        .rsp_no_alloc (rsp_no_alloc), .rsp_wb (rsp_wb)
    );

    task automatic check(input bit ok, input string rq, input string what);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", rq, what);
        end
    endtask

    task automatic model_reset();
        for (int s = 0; s < SETS; s++) begin
            m_rr[s] = 0;
            for (int w = 0; w < WAYS; w++) begin
                m_tag[s][w] = 0; m_st[s][w] = 0; m_lk[s][w] = 0;
            end
        end
    endtask

    function automatic string op_req(input int op);
        case (op)
            1: return "R2";  2: return "R3";  3: return "R7";
            4: return "R4";  5: return "R5";  6: return "R6";
            7: return "R10"; 8: return "R11"; default: return "R2";
        endcase
    endfunction

    // Issue one request, predict the response from the model, compare.
    task automatic issue(input int op, input int s, input int t, input string rq);
        int hw = -1;
        bit e_hit = 0, e_miss = 0, e_lock = 0, e_na = 0, e_wb = 0;
        int e_way = 0, e_st = 0;
        for (int w = 0; w < WAYS; w++)
            if (m_st[s][w] != 0 && m_tag[s][w] == t) hw = w;
        case (op)
            1, 2, 4, 5, 7: begin
                if (hw >= 0) begin
                    e_hit = 1; e_way = hw;
                    if (op == 2) m_st[s][hw] = 3;
                    if (op == 4) m_lk[s][hw] = 1;
                    if (op == 5) m_lk[s][hw] = 0;
                    if (op == 7) begin m_st[s][hw] = 0; m_lk[s][hw] = 0; end
                    e_st = m_st[s][hw]; e_lock = m_lk[s][hw];
                end else e_miss = 1;
            end
            3: begin
                if (hw >= 0) begin
                    e_hit = 1; e_way = hw; e_st = m_st[s][hw]; e_lock = m_lk[s][hw];
                end else begin
                    int v = -1;
                    for (int w = WAYS - 1; w >= 0; w--) if (m_st[s][w] == 0) v = w;
                    if (v < 0)
                        for (int k = 0; k < WAYS; k++) begin
                            int idx = (m_rr[s] + k) % WAYS;
                            if (v < 0 && !m_lk[s][idx]) v = idx;
                        end
                    if (v < 0) e_na = 1;
                    else begin
                        e_wb = (m_st[s][v] == 3);
                        m_tag[s][v] = t; m_st[s][v] = 1; m_lk[s][v] = 0;
                        m_rr[s] = (v + 1) % WAYS;
                        e_way = v; e_st = 1;
                    end
                end
            end
            6: for (int a = 0; a < SETS; a++) for (int w = 0; w < WAYS; w++) m_lk[a][w] = 0;
            8: for (int a = 0; a < SETS; a++) for (int w = 0; w < WAYS; w++) begin
                   m_lk[a][w] = 0; m_st[a][w] = 0;
               end
            default: ;
        endcase
        req_valid = 1'b1;
        req_op    = 4'(op);
        req_set   = SET_W'(s);
        req_tag   = TAG_W'(t);
        @(posedge clk);
        #1;
        check(rsp_valid && rsp_hit == e_hit && rsp_miss == e_miss && int'(rsp_way) == e_way &&
              int'(rsp_state) == e_st && rsp_locked == e_lock && rsp_no_alloc == e_na &&
              rsp_wb == e_wb, rq,
              $sformatf("op%0d set%0d tag%0d got v%0b h%0b m%0b w%0d s%0d l%0b na%0b wb%0b exp v1 h%0b m%0b w%0d s%0d l%0b na%0b wb%0b",
                        op, s, t, rsp_valid, rsp_hit, rsp_miss, rsp_way, rsp_state, rsp_locked,
                        rsp_no_alloc, rsp_wb, e_hit, e_miss, e_way, e_st, e_lock, e_na, e_wb));
    endtask

    initial begin
        model_reset();
        // R1: response stays quiet during reset even with a request present
        req_valid = 1'b1; req_op = 4'(OP_READ);
        repeat (3) @(posedge clk);
        #1;
        check(rsp_valid == 1'b0, "R1", $sformatf("rsp_valid in reset got %0b exp 0", rsp_valid));
        rst_n = 1'b1;
        // R1: tag 0 matches the reset tag value yet must miss
        issue(1, 0, 0, "R1");
        // R7: invalid ways fill lowest first
        issue(3, 2, 10, "R7"); issue(3, 2, 11, "R7");
        issue(3, 2, 12, "R7"); issue(3, 2, 13, "R7");
        issue(3, 2, 12, "R7");                       // already resident
        issue(1, 2, 11, "R2");
        issue(2, 2, 11, "R3"); issue(2, 2, 99, "R3");
        issue(1, 2, 99, "R3");
        issue(4, 2, 10, "R4"); issue(4, 2, 12, "R4");
        issue(4, 2, 77, "R9"); issue(5, 2, 77, "R9");
        issue(7, 2, 77, "R9"); issue(1, 2, 77, "R9");
        // R7/R8: round-robin skips locked way 0, evicts dirty way 1
        issue(3, 2, 20, "R8");
        issue(3, 2, 21, "R7");
        issue(4, 2, 20, "R4"); issue(4, 2, 21, "R4");
        issue(3, 2, 22, "R7");                       // every way locked
        issue(1, 2, 22, "R7");
        issue(5, 2, 10, "R5"); issue(1, 2, 10, "R5"); issue(1, 2, 12, "R5");
        issue(6, 0, 0, "R6");
        issue(1, 2, 12, "R6"); issue(1, 2, 21, "R6");
        issue(4, 2, 20, "R10"); issue(7, 2, 20, "R10");
        issue(1, 2, 20, "R10"); issue(3, 2, 30, "R10");
        issue(3, 5, 40, "R7"); issue(4, 5, 40, "R4");
        issue(8, 0, 0, "R11");
        issue(1, 5, 40, "R11"); issue(1, 2, 30, "R11");
        issue(0, 2, 30, "R2");  issue(12, 2, 30, "R2");
        // Random traffic against the reference model.
        for (int i = 0; i < 3000; i++) begin
            int op = $urandom_range(0, 8);
            if (op == 8 && $urandom_range(0, 9) != 0) op = 3;
            issue(op, $urandom_range(0, 1), $urandom_range(0, 5), op_req(op));
        end
        req_valid = 1'b0;
        @(posedge clk);
        #1;
        check(rsp_valid == 1'b0, "R2", $sformatf("idle rsp_valid got %0b exp 0", rsp_valid));
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, got timeout exp completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule